// File: doc/BRIEF.md
# Branch Decode and Next-PC Unit

This unit sits beside the execute stage of a 64-bit core and resolves control flow for one instruction at a time. It looks at a 32-bit instruction word, recognises whether it is a control-transfer instruction, and works out the address of the next instruction together with a link-register write request when the instruction saves a return address. The two source-register indices are taken straight from the instruction word and sent out combinationally, so that an external register file can return their values in the same cycle. An 8-entry condition-flag vector is also an input.

A caller places the instruction, its PC, the operand values and the flags on the inputs and raises the valid strobe for one cycle. On the next rising clock edge the unit captures its decision: whether the word was a branch, whether the branch is taken, the next PC, and the link write. These registered results hold their values until the next strobe. The unit does not fetch instructions, predict branches, raise exceptions or write the register file itself.

Top module: `brnpc_unit`

## Requirements
- R1: While reset is high, and after it on the first edge, every registered output is zero (is_branch, taken, next_pc, link_we, link_idx, link_data).
- R2: The registered outputs change only on a rising edge where valid_i is high; with valid_i low they keep their values whatever the other inputs do.
- R3: The primary opcode sits in instr[31:26]. An opcode outside 0x10..0x1B, or an opcode 0x12 whose bits 9:8 are 10 or 11, gives is_branch=0, taken=0, next_pc=PC+4 and no link write.
- R4: Opcode 0x10 is taken when the rj value is zero and opcode 0x11 is taken when it is nonzero. Their 21-bit offset has instr[4:0] as bits 20:16 and instr[25:10] as bits 15:0, is shifted left by 2 and sign-extended from bit 22, and a taken branch goes to PC plus that offset.
- R5: Opcode 0x12 tests flag number instr[7:5]; bits 9:8 = 00 branch when that flag is 0, 01 branch when it is 1. The offset is built as in R4.
- R6: Opcode 0x14 is always taken to PC plus a 26-bit offset whose bits 25:16 come from instr[9:0] and bits 15:0 from instr[25:10], shifted left by 2 and sign-extended from bit 27.
- R7: Opcode 0x15 jumps as in R6 and writes PC+4 to register 1.
- R8: Opcode 0x13 is always taken to the rj value plus instr[25:10] shifted left by 2 and sign-extended from bit 17, and writes PC+4 to register instr[4:0].
- R9: Opcode 0x16 branches when the rj and rd values are equal, 0x17 when they differ, using the 16-bit offset of R8 added to PC; any conditional branch that is not taken goes to PC+4.
- R10: Opcodes 0x18 (less) and 0x19 (greater or equal) compare rj with rd as signed 64-bit values; 0x1A and 0x1B do the same comparisons unsigned.
- R11: A link write to register 0 is dropped: link_we stays 0. When link_we is 0, link_idx and link_data are 0; when it is 1, link_data is PC+4.
- R12: rj_idx_o equals instr[9:5] and rd_idx_o equals instr[4:0] combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Strobe: evaluate the instruction on this edge |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 64 | Address of the instruction |
| rj_idx_o | output | 5 | First source register index to the register file |
| rd_idx_o | output | 5 | Second source register index to the register file |
| rj_val_i | input | 64 | Value of register rj |
| rd_val_i | input | 64 | Value of register rd |
| flags_i | input | 8 | Condition-flag vector |
| is_branch_o | output | 1 | Registered: instruction was a control transfer |
| taken_o | output | 1 | Registered: control transfer is taken |
| next_pc_o | output | 64 | Registered: address of the next instruction |
| link_we_o | output | 1 | Registered: link-register write request |
| link_idx_o | output | 5 | Registered: link destination register |
| link_data_o | output | 64 | Registered: return address to write |

## Verification
The register indices are due in the same cycle as the instruction and are checked a short delay after the inputs change, before any clock edge. Every other result is due on the first rising edge after the strobe, so the reference model in the bench updates its expected values on that same edge and the comparison runs at the following falling edge, away from the edge where the outputs move. Cycles with the strobe low are compared against the held values, which covers the hold behaviour with fresh, unrelated inputs present.

// File: rtl/brnpc_pkg.sv
package brnpc_pkg;

    localparam int INSN_W    = 32;
    localparam int RIDX_W    = 5;
    localparam int OFF_W     = 28;
    localparam int FLAGS_N   = 8;
    localparam int FSEL_W    = $clog2(FLAGS_N);
    localparam int CALL_REG  = 1;

    localparam logic [5:0] OPC_ZERO  = 6'h10;
    localparam logic [5:0] OPC_NZERO = 6'h11;
    localparam logic [5:0] OPC_FLAG  = 6'h12;
    localparam logic [5:0] OPC_JIND  = 6'h13;
    localparam logic [5:0] OPC_JMP   = 6'h14;
    localparam logic [5:0] OPC_CALL  = 6'h15;
    localparam logic [5:0] OPC_EQ    = 6'h16;
    localparam logic [5:0] OPC_NE    = 6'h17;
    localparam logic [5:0] OPC_LT    = 6'h18;
    localparam logic [5:0] OPC_GE    = 6'h19;
    localparam logic [5:0] OPC_LTU   = 6'h1A;
    localparam logic [5:0] OPC_GEU   = 6'h1B;

    typedef enum logic [3:0] {
        K_NONE, K_RZERO, K_RNZERO, K_FZERO, K_FSET,
        K_JIND, K_JMP, K_CALL,
        K_EQ, K_NE, K_LT, K_GE, K_LTU, K_GEU
    } br_kind_e;

    typedef struct packed {
        br_kind_e             kind;
        logic [RIDX_W-1:0]    rj;
        logic [RIDX_W-1:0]    rd;
        logic [FSEL_W-1:0]    fsel;
        logic [OFF_W-1:0]     off;
        logic                 link;
        logic [RIDX_W-1:0]    link_idx;
    } br_dec_t;

    function automatic logic [OFF_W-1:0] off_w21(input logic [20:0] f);
        return {{(OFF_W-23){f[20]}}, f, 2'b00};
    endfunction

    function automatic logic [OFF_W-1:0] off_w26(input logic [25:0] f);
        return {f, 2'b00};
    endfunction

    function automatic logic [OFF_W-1:0] off_w16(input logic [15:0] f);
        return {{(OFF_W-18){f[15]}}, f, 2'b00};
    endfunction

endpackage

// File: rtl/brnpc_decode.sv
module brnpc_decode
    import brnpc_pkg::*;
(
    input  logic [INSN_W-1:0] instr,
    output br_dec_t           dec
);
    logic [5:0]  opc;
    logic [20:0] f21;
    logic [25:0] f26;
    logic [15:0] f16;

    assign opc = instr[31:26];
    assign f16 = instr[25:10];
    assign f21 = {instr[4:0], instr[25:10]};
    assign f26 = {instr[9:0], instr[25:10]};

    always_comb begin
        dec          = '0;
        dec.kind     = K_NONE;
        dec.rj       = instr[9:5];
        dec.rd       = instr[4:0];
        dec.fsel     = instr[5 +: FSEL_W];
        case (opc)
            OPC_ZERO:  begin dec.kind = K_RZERO;  dec.off = off_w21(f21); end
            OPC_NZERO: begin dec.kind = K_RNZERO; dec.off = off_w21(f21); end
            OPC_FLAG: begin
                dec.off = off_w21(f21);
                case (instr[9:8])
                    2'b00:   dec.kind = K_FZERO;
                    2'b01:   dec.kind = K_FSET;
                    default: dec.kind = K_NONE;
                endcase
            end
            OPC_JIND: begin
                dec.kind     = K_JIND;
                dec.off      = off_w16(f16);
                dec.link     = 1'b1;
                dec.link_idx = instr[4:0];
            end
            OPC_JMP:   begin dec.kind = K_JMP; dec.off = off_w26(f26); end
            OPC_CALL: begin
                dec.kind     = K_CALL;
                dec.off      = off_w26(f26);
                dec.link     = 1'b1;
                dec.link_idx = RIDX_W'(CALL_REG);
            end
            OPC_EQ:    begin dec.kind = K_EQ;  dec.off = off_w16(f16); end
            OPC_NE:    begin dec.kind = K_NE;  dec.off = off_w16(f16); end
            OPC_LT:    begin dec.kind = K_LT;  dec.off = off_w16(f16); end
            OPC_GE:    begin dec.kind = K_GE;  dec.off = off_w16(f16); end
            OPC_LTU:   begin dec.kind = K_LTU; dec.off = off_w16(f16); end
            OPC_GEU:   begin dec.kind = K_GEU; dec.off = off_w16(f16); end
            default:   dec.kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/brnpc_cond.sv
module brnpc_cond
    import brnpc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  br_kind_e          kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [FLAGS_N-1:0] flags,
    input  logic [FSEL_W-1:0] fsel,
    output logic              is_br,
    output logic              take
);
    logic a_zero, eq, lt_s, lt_u, flag_bit;

    assign a_zero   = (a == '0);
    assign eq       = (a == b);
    assign lt_s     = ($signed(a) < $signed(b));
    assign lt_u     = (a < b);
    assign flag_bit = flags[fsel];

    always_comb begin
        is_br = 1'b1;
        take  = 1'b0;
        case (kind)
            K_RZERO:  take = a_zero;
            K_RNZERO: take = !a_zero;
            K_FZERO:  take = !flag_bit;
            K_FSET:   take = flag_bit;
            K_JIND,
            K_JMP,
            K_CALL:   take = 1'b1;
            K_EQ:     take = eq;
            K_NE:     take = !eq;
            K_LT:     take = lt_s;
            K_GE:     take = !lt_s;
            K_LTU:    take = lt_u;
            K_GEU:    take = !lt_u;
            default:  is_br = 1'b0;
        endcase
    end
endmodule

// File: rtl/brnpc_target.sv
module brnpc_target
    import brnpc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [XLEN-1:0]  rj_val,
    input  logic             indirect,
    input  logic             take,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  next_pc
);
    localparam int EXT_W = XLEN - OFF_W;

    logic [XLEN-1:0] off_x;
    logic [XLEN-1:0] base;
    logic [XLEN-1:0] tgt;

    assign off_x   = {{EXT_W{off[OFF_W-1]}}, off};
    assign base    = indirect ? rj_val : pc;
    assign tgt     = base + off_x;
    assign seq_pc  = pc + XLEN'(4);
    assign next_pc = take ? tgt : seq_pc;
endmodule

// File: rtl/brnpc_unit.sv
module brnpc_unit
    import brnpc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [INSN_W-1:0]   instr_i,
    input  logic [XLEN-1:0]     pc_i,
    output logic [RIDX_W-1:0]   rj_idx_o,
    output logic [RIDX_W-1:0]   rd_idx_o,
    input  logic [XLEN-1:0]     rj_val_i,
    input  logic [XLEN-1:0]     rd_val_i,
    input  logic [FLAGS_N-1:0]  flags_i,
    output logic                is_branch_o,
    output logic                taken_o,
    output logic [XLEN-1:0]     next_pc_o,
    output logic                link_we_o,
    output logic [RIDX_W-1:0]   link_idx_o,
    output logic [XLEN-1:0]     link_data_o
);
    br_dec_t         dec;
    logic            is_br, take, link_en;
    logic [XLEN-1:0] seq_pc, nxt;

    brnpc_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    brnpc_cond #(.XLEN(XLEN)) u_cond (
        .kind  (dec.kind),
        .a     (rj_val_i),
        .b     (rd_val_i),
        .flags (flags_i),
        .fsel  (dec.fsel),
        .is_br (is_br),
        .take  (take)
    );

    brnpc_target #(.XLEN(XLEN)) u_tgt (
        .pc       (pc_i),
        .rj_val   (rj_val_i),
        .indirect (dec.kind == K_JIND),
        .take     (take),
        .off      (dec.off),
        .seq_pc   (seq_pc),
        .next_pc  (nxt)
    );

    assign rj_idx_o = dec.rj;
    assign rd_idx_o = dec.rd;
    assign link_en  = dec.link && (dec.link_idx != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            is_branch_o <= 1'b0;
            taken_o     <= 1'b0;
            next_pc_o   <= '0;
            link_we_o   <= 1'b0;
            link_idx_o  <= '0;
            link_data_o <= '0;
        end else if (valid_i) begin
            is_branch_o <= is_br;
            taken_o     <= take;
            next_pc_o   <= nxt;
            link_we_o   <= link_en;
            link_idx_o  <= link_en ? dec.link_idx : '0;
            link_data_o <= link_en ? seq_pc : '0;
        end
    end
endmodule

// File: rtl/brnpc_checker.sv
module brnpc_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            valid_i,
    input logic [31:0]     instr_i,
    input logic [XLEN-1:0] pc_i,
    input logic            is_branch_o,
    input logic            taken_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            link_we_o,
    input logic [4:0]      link_idx_o,
    input logic [XLEN-1:0] link_data_o
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(is_branch_o)
                      && $stable(link_we_o) && $stable(link_idx_o) && $stable(link_data_o)));

    assert_nonbranch_R3: assert property (@(posedge clk) disable iff (rst)
        !is_branch_o |-> (!taken_o && !link_we_o));

    assert_seq_pc_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(4)));

    assert_call_link_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[31:26] == 6'h15) |=> (link_we_o && link_idx_o == 5'd1 && taken_o));

    assert_jind_link_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && instr_i[31:26] == 6'h13 && instr_i[4:0] != 5'd0)
        |=> (link_we_o && link_idx_o == $past(instr_i[4:0])
             && link_data_o == $past(pc_i) + XLEN'(4)));

    assert_no_r0_R11: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_idx_o != 5'd0));

    assert_idle_link_R11: assert property (@(posedge clk) disable iff (rst)
        !link_we_o |-> (link_idx_o == 5'd0 && link_data_o == '0));
endmodule

bind brnpc_unit brnpc_checker #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .instr_i     (instr_i),
    .pc_i        (pc_i),
    .is_branch_o (is_branch_o),
    .taken_o     (taken_o),
    .next_pc_o   (next_pc_o),
    .link_we_o   (link_we_o),
    .link_idx_o  (link_idx_o),
    .link_data_o (link_data_o)
);

// File: tb/brnpc_unit_tb.sv
`timescale 1ns/1ps
module brnpc_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] pc_i = '0;
    logic [4:0]  rj_idx_o, rd_idx_o;
    logic [63:0] rj_val_i = '0, rd_val_i = '0;
    logic [7:0]  flags_i = '0;
    logic        is_branch_o, taken_o, link_we_o;
    logic [63:0] next_pc_o, link_data_o;
    logic [4:0]  link_idx_o;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    chk_en = 1'b0;

    logic        e_br, e_tk, e_lwe;
    logic [63:0] e_npc, e_ldat;
    logic [4:0]  e_lidx;

    always #2.5 clk = ~clk;

    brnpc_unit u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .rj_idx_o(rj_idx_o), .rd_idx_o(rd_idx_o), .rj_val_i(rj_val_i), .rd_val_i(rd_val_i),
        .flags_i(flags_i), .is_branch_o(is_branch_o), .taken_o(taken_o),
        .next_pc_o(next_pc_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
        .link_data_o(link_data_o)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural reference: evaluate one instruction per the requirements.
    task automatic ref_eval(input logic [31:0] w, input logic [63:0] pc,
                            input logic [63:0] a, input logic [63:0] b, input logic [7:0] fl);
        logic signed [15:0] t16;
        logic signed [20:0] t21;
        logic signed [25:0] t26;
        logic signed [63:0] o16, o21, o26;
        int  op;
        bit  br, tk, lk;
        logic [63:0] tgt;
        logic [4:0]  li;
        t16 = w[25:10];
        t21 = {w[4:0], w[25:10]};
        t26 = {w[9:0], w[25:10]};
        o16 = t16; o16 = o16 * 4;
        o21 = t21; o21 = o21 * 4;
        o26 = t26; o26 = o26 * 4;
        op  = int'(w[31:26]);
        br = 1; tk = 0; lk = 0; li = 0; tgt = pc + 64'(o16);
        case (op)
            16: begin tk = (a == 0); tgt = pc + 64'(o21); end
            17: begin tk = (a != 0); tgt = pc + 64'(o21); end
            18: begin
                tgt = pc + 64'(o21);
                if (w[9:8] == 2'b00)      tk = (fl[w[7:5]] == 1'b0);
                else if (w[9:8] == 2'b01) tk = (fl[w[7:5]] == 1'b1);
                else br = 0;
            end
            19: begin tk = 1; tgt = a + 64'(o16); lk = 1; li = w[4:0]; end
            20: begin tk = 1; tgt = pc + 64'(o26); end
            21: begin tk = 1; tgt = pc + 64'(o26); lk = 1; li = 5'd1; end
            22: tk = (a == b);
            23: tk = (a != b);
            24: tk = ($signed(a) <  $signed(b));
            25: tk = ($signed(a) >= $signed(b));
            26: tk = (a <  b);
            27: tk = (a >= b);
            default: br = 0;
        endcase
        if (li == 0) lk = 0;
        e_br   = br;
        e_tk   = tk;
        e_npc  = tk ? tgt : pc + 64'd4;
        e_lwe  = lk;
        e_lidx = lk ? li : 5'd0;
        e_ldat = lk ? pc + 64'd4 : 64'd0;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            e_br = 0; e_tk = 0; e_npc = 0; e_lwe = 0; e_lidx = 0; e_ldat = 0;
        end else if (valid_i) begin
            ref_eval(instr_i, pc_i, rj_val_i, rd_val_i, flags_i);
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            chk("is_branch", 64'(is_branch_o), 64'(e_br));
            chk("taken",     64'(taken_o),     64'(e_tk));
            chk("next_pc",   next_pc_o,        e_npc);
            chk("link_we",   64'(link_we_o),   64'(e_lwe));
            chk("link_idx",  64'(link_idx_o),  64'(e_lidx));
            chk("link_data", link_data_o,      e_ldat);
        end
    end

    task automatic issue(input string rq, input logic [31:0] w, input logic [63:0] pc,
                         input logic [63:0] a, input logic [63:0] b, input logic [7:0] fl);
        @(negedge clk);
        #0.1;
        cur_req = rq;
        valid_i = 1; instr_i = w; pc_i = pc; rj_val_i = a; rd_val_i = b; flags_i = fl;
        #0.5;
        begin
            string keep;
            keep = cur_req;
            cur_req = "R12";
            chk("rj_idx", 64'(rj_idx_o), 64'(w[9:5]));
            chk("rd_idx", 64'(rd_idx_o), 64'(w[4:0]));
            cur_req = keep;
        end
        @(posedge clk);
        #0.5;
        valid_i = 0;
    endtask

    task automatic idle(input string rq);
        @(negedge clk);
        #0.1;
        cur_req = rq;
        instr_i = {6'h14, 26'h3ff_ffff}; pc_i = 64'hdead_beef_0000_1000;
        rj_val_i = 64'h1234; rd_val_i = 64'h1234; flags_i = 8'hff;
        @(posedge clk);
    endtask

    function automatic logic [31:0] f16(input logic [5:0] op, input logic [15:0] o,
                                        input logic [4:0] rj, input logic [4:0] rd);
        return {op, o, rj, rd};
    endfunction
    function automatic logic [31:0] f21(input logic [5:0] op, input logic [20:0] o,
                                        input logic [4:0] mid);
        return {op, o[15:0], mid, o[20:16]};
    endfunction
    function automatic logic [31:0] fflag(input logic [20:0] o, input logic [1:0] sub,
                                          input logic [2:0] idx);
        return {6'h12, o[15:0], sub, idx, o[20:16]};
    endfunction
    function automatic logic [31:0] f26(input logic [5:0] op, input logic [25:0] o);
        return {op, o[15:0], o[25:16]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        chk_en = 1;
        cur_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: first edge after reset, nothing issued
        @(posedge clk);
        // R4: zero / nonzero register branches
        issue("R4", f21(6'h10, 21'h00040, 5'd3), 64'h1000, 64'd0, 64'd9, 8'h00);
        issue("R4", f21(6'h10, 21'h00040, 5'd3), 64'h1000, 64'd5, 64'd9, 8'h00);
        issue("R4", f21(6'h11, 21'h100000, 5'd7), 64'h0080_0000, 64'd5, 64'd0, 8'h00);
        issue("R4", f21(6'h11, 21'h0ffff, 5'd7), 64'h2000, 64'd0, 64'd0, 8'h00);
        // R5: flag branches
        issue("R5", fflag(21'h1ffff0, 2'b00, 3'd3), 64'h4000, 64'd0, 64'd0, 8'hf7);
        issue("R5", fflag(21'h1ffff0, 2'b00, 3'd3), 64'h4000, 64'd0, 64'd0, 8'h08);
        issue("R5", fflag(21'h00010, 2'b01, 3'd7), 64'h4000, 64'd0, 64'd0, 8'h80);
        issue("R5", fflag(21'h00010, 2'b01, 3'd7), 64'h4000, 64'd0, 64'd0, 8'h7f);
        issue("R5", fflag(21'h00010, 2'b10, 3'd0), 64'h4000, 64'd0, 64'd0, 8'h00);
        issue("R5", fflag(21'h00010, 2'b11, 3'd0), 64'h4000, 64'd0, 64'd0, 8'hff);
        // R6 / R7: PC-relative jumps
        issue("R6", f26(6'h14, 26'h2000001), 64'h1_0000_0000, 64'd0, 64'd0, 8'h00);
        issue("R6", f26(6'h14, 26'h0123456), 64'h100, 64'd0, 64'd0, 8'h00);
        issue("R7", f26(6'h15, 26'h3ffffff), 64'h8000, 64'd0, 64'd0, 8'h00);
        // R8 / R11: indirect jump and link suppression
        issue("R8", f16(6'h13, 16'h8001, 5'd4, 5'd3), 64'h3000, 64'h10_0000, 64'd0, 8'h00);
        issue("R8", f16(6'h13, 16'h0010, 5'd31, 5'd31), 64'h3004, 64'h7ffc, 64'd0, 8'h00);
        issue("R11", f16(6'h13, 16'h0010, 5'd4, 5'd0), 64'h3008, 64'h500, 64'd0, 8'h00);
        // R9: equality compares
        issue("R9", f16(6'h16, 16'hfff0, 5'd1, 5'd2), 64'h5000, 64'd77, 64'd77, 8'h00);
        issue("R9", f16(6'h16, 16'hfff0, 5'd1, 5'd2), 64'h5000, 64'd77, 64'd78, 8'h00);
        issue("R9", f16(6'h17, 16'h0020, 5'd1, 5'd2), 64'h5000, 64'd1, 64'd2, 8'h00);
        issue("R9", f16(6'h17, 16'h0020, 5'd1, 5'd2), 64'h5000, 64'd2, 64'd2, 8'h00);
        // R10: signed versus unsigned compares
        issue("R10", f16(6'h18, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'hffff_ffff_ffff_ffff, 64'd1, 8'h00);
        issue("R10", f16(6'h1A, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'hffff_ffff_ffff_ffff, 64'd1, 8'h00);
        issue("R10", f16(6'h19, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'd5, 64'd5, 8'h00);
        issue("R10", f16(6'h19, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'h8000_0000_0000_0000, 64'd0, 8'h00);
        issue("R10", f16(6'h1B, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'h8000_0000_0000_0000, 64'd0, 8'h00);
        issue("R10", f16(6'h1B, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'd3, 64'd4, 8'h00);
        issue("R10", f16(6'h1A, 16'h0040, 5'd1, 5'd2), 64'h6000, 64'd3, 64'd4, 8'h00);
        // R3: words that are not control transfers
        issue("R3", 32'h0000_0000, 64'h7000, 64'd0, 64'd0, 8'h00);
        issue("R3", {6'h1C, 26'h0}, 64'h7004, 64'd0, 64'd0, 8'h00);
        issue("R3", {6'h0F, 26'h3ffffff}, 64'hffff_ffff_ffff_fffc, 64'd0, 64'd0, 8'h00);
        // R2: hold with strobe low after a linked call
        issue("R7", f26(6'h15, 26'h0000004), 64'h9000, 64'd0, 64'd0, 8'h00);
        idle("R2");
        idle("R2");
        @(negedge clk);
        #0.1;
        chk_en = 0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule